// File: doc/BRIEF.md
# Integer ALU with Packed Status Word

This block is a two-operand integer arithmetic and logic unit that keeps its condition codes in a 32-bit status word. Each accepted operation computes its result in one combinational pass. The result, a write strobe and the updated status word are all captured on the next rising clock edge. Add and subtract can chain through the stored carry bit, which allows multi-word arithmetic. A compare sets the condition codes but does not write back a result.

The status word holds condition bits and control bits at fixed positions. The condition bits are carry, even parity of the low result byte, nibble carry, zero, sign and signed overflow. The control bits are a trap enable, an interrupt enable and a 2-bit I/O privilege level. The control bits can be changed only through a separate privileged load port. Bit 1 always reads as one. Every other unassigned bit always reads as zero.

Top module: `alu_flagword`

## Requirements
- R1: While `rst` is high at a clock edge, `res_q` becomes 0, `res_wr` becomes 0 and `flags_q` becomes 32'h0000_0002.
- R2: With `op_valid` high, the operation is selected by `op_code`: 0 add, 1 add with carry (carry-in = flags bit 0), 2 subtract, 3 subtract with borrow (borrow-in = flags bit 0), 4 AND, 5 OR, 6 XOR, 7 compare. For codes 0 to 6, the result appears on `res_q` after the next edge, and `res_wr` is high for that one cycle.
- R3: Bit 0 (carry) is the unsigned carry out of the top bit for add operations. For subtract and compare it is the borrow, set when A < B + borrow-in as unsigned numbers.
- R4: Bit 2 (parity) is set when result bits 7:0 contain an even number of ones.
- R5: Bit 4 (nibble carry) is the carry out of bit 3 for add operations and the borrow out of bit 3 for subtract and compare. It is 0 after AND, OR and XOR.
- R6: Bit 6 (zero) is set when every result bit is 0. Bit 7 (sign) equals the top result bit.
- R7: Bit 11 (overflow) is set when the signed result does not fit in the data width. AND, OR and XOR clear both bit 11 and bit 0.
- R8: Compare (code 7) updates the condition bits exactly as subtract would. It leaves `res_wr` low and `res_q` unchanged.
- R9: When `op_valid` is low, or `op_code` is 8 to 15, `res_q` and the condition bits are unchanged and `res_wr` is low.
- R10: When `priv_wr` is high at an edge, bits 8 (trap enable), 9 (interrupt enable) and 13:12 (I/O privilege) are loaded from `priv_data`. This load does not change the condition bits. An operation in the same cycle still updates the condition bits. Without `priv_wr`, bits 8, 9, 13 and 12 never change.
- R11: Bit 1 of `flags_q` is always 1. Bits 3, 5, 10 and 31:14 are always 0, even when `priv_data` has them set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request this cycle |
| op_code | input | 4 | Operation select |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| priv_wr | input | 1 | Privileged load of control bits |
| priv_data | input | 32 | Value for the privileged load |
| res_q | output | DATA_W | Registered result |
| res_wr | output | 1 | Result writeback strobe |
| flags_q | output | 32 | Registered status word |

## Verification
The bench builds the block with the default 32-bit data width. At that width the full unsigned and signed limits can be driven directly: 0x7FFFFFFF + 1 for overflow, 0xFFFFFFFF + 1 for carry and zero together, and 0 - 1 for borrow. Carry and borrow chains through the stored flag are run against the same 32-bit boundaries. The bench also covers privileged loads that try to set reserved bits, and privileged loads that coincide with an operation.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int FLAG_W = 32;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_ADC = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_SBB = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4;
  localparam logic [3:0] OP_OR  = 4'd5;
  localparam logic [3:0] OP_XOR = 4'd6;
  localparam logic [3:0] OP_CMP = 4'd7;

  localparam int B_CF   = 0;
  localparam int B_ONE  = 1;
  localparam int B_PF   = 2;
  localparam int B_AF   = 4;
  localparam int B_ZF   = 6;
  localparam int B_SF   = 7;
  localparam int B_TE   = 8;
  localparam int B_IE   = 9;
  localparam int B_OF   = 11;
  localparam int B_PL0  = 12;
  localparam int B_PL1  = 13;

  localparam logic [FLAG_W-1:0] MASK_CTRL = (FLAG_W'(1) << B_TE) | (FLAG_W'(1) << B_IE)
                                          | (FLAG_W'(1) << B_PL0) | (FLAG_W'(1) << B_PL1);
  localparam logic [FLAG_W-1:0] MASK_COND = (FLAG_W'(1) << B_CF) | (FLAG_W'(1) << B_PF)
                                          | (FLAG_W'(1) << B_AF) | (FLAG_W'(1) << B_ZF)
                                          | (FLAG_W'(1) << B_SF) | (FLAG_W'(1) << B_OF);
  localparam logic [FLAG_W-1:0] FIXED_SET = FLAG_W'(1) << B_ONE;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } cond_t;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              chain_in,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              nib_carry,
  output logic              ovf
);
  localparam int NIB = 4;

  logic [DATA_W-1:0] b_eff;
  logic              c_in;
  logic [DATA_W:0]   full;
  logic [NIB:0]      low;

  always_comb begin
    b_eff = sub ? ~b : b;
    c_in  = sub ? ~chain_in : chain_in;
    full  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_in};
    low   = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_in};
    sum       = full[DATA_W-1:0];
    carry     = sub ? ~full[DATA_W] : full[DATA_W];
    nib_carry = sub ? ~low[NIB] : low[NIB];
    ovf       = (a[DATA_W-1] == b_eff[DATA_W-1]) && (full[DATA_W-1] != a[DATA_W-1]);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]      a,
  input  logic [DATA_W-1:0]      b,
  input  alu_pkg::logic_sel_e    sel,
  output logic [DATA_W-1:0]      y
);
  always_comb begin
    unique case (sel)
      alu_pkg::LG_AND: y = a & b;
      alu_pkg::LG_OR:  y = a | b;
      alu_pkg::LG_XOR: y = a ^ b;
      default:         y = '0;
    endcase
  end
endmodule

// File: rtl/alu_cond_gen.sv
module alu_cond_gen #(
  parameter int DATA_W = 32,
  parameter int PAR_W  = 8
) (
  input  logic [DATA_W-1:0] result,
  input  logic              is_logic,
  input  logic              carry,
  input  logic              nib_carry,
  input  logic              ovf,
  output alu_pkg::cond_t    cond
);
  logic [PAR_W:0] par_chain;

  assign par_chain[0] = 1'b1;
  for (genvar i = 0; i < PAR_W; i++) begin : g_par
    assign par_chain[i+1] = par_chain[i] ^ result[i];
  end

  always_comb begin
    cond.cf = is_logic ? 1'b0 : carry;
    cond.af = is_logic ? 1'b0 : nib_carry;
    cond.of = is_logic ? 1'b0 : ovf;
    cond.pf = par_chain[PAR_W];
    cond.zf = (result == '0);
    cond.sf = result[DATA_W-1];
  end
endmodule

// File: rtl/alu_flagword.sv
module alu_flagword #(
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       op_valid,
  input  logic [3:0]                 op_code,
  input  logic [DATA_W-1:0]          opnd_a,
  input  logic [DATA_W-1:0]          opnd_b,
  input  logic                       priv_wr,
  input  logic [alu_pkg::FLAG_W-1:0] priv_data,
  output logic [DATA_W-1:0]          res_q,
  output logic                       res_wr,
  output logic [alu_pkg::FLAG_W-1:0] flags_q
);
  import alu_pkg::*;

  localparam int PAR_W = (DATA_W < 8) ? DATA_W : 8;

  logic              op_ok;
  logic              do_wb;
  logic              is_sub;
  logic              is_chain;
  logic              is_logic;
  logic [DATA_W-1:0] arith_y;
  logic [DATA_W-1:0] logic_y;
  logic [DATA_W-1:0] result;
  logic              a_carry;
  logic              a_nib;
  logic              a_ovf;
  cond_t             cond;
  logic_sel_e        lsel;
  logic [FLAG_W-1:0] flags_nxt;

  always_comb begin
    op_ok    = op_valid && !op_code[3];
    do_wb    = op_ok && (op_code != OP_CMP);
    is_sub   = (op_code == OP_SUB) || (op_code == OP_SBB) || (op_code == OP_CMP);
    is_chain = (op_code == OP_ADC) || (op_code == OP_SBB);
    is_logic = (op_code == OP_AND) || (op_code == OP_OR) || (op_code == OP_XOR);
    lsel     = logic_sel_e'(op_code[1:0]);
    result   = is_logic ? logic_y : arith_y;
  end

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a         (opnd_a),
    .b         (opnd_b),
    .sub       (is_sub),
    .chain_in  (is_chain && flags_q[B_CF]),
    .sum       (arith_y),
    .carry     (a_carry),
    .nib_carry (a_nib),
    .ovf       (a_ovf)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a   (opnd_a),
    .b   (opnd_b),
    .sel (lsel),
    .y   (logic_y)
  );

  alu_cond_gen #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_cond (
    .result    (result),
    .is_logic  (is_logic),
    .carry     (a_carry),
    .nib_carry (a_nib),
    .ovf       (a_ovf),
    .cond      (cond)
  );

  always_comb begin
    flags_nxt = flags_q;
    if (priv_wr) begin
      flags_nxt = (flags_nxt & ~MASK_CTRL) | (priv_data & MASK_CTRL);
    end
    if (op_ok) begin
      flags_nxt[B_CF] = cond.cf;
      flags_nxt[B_PF] = cond.pf;
      flags_nxt[B_AF] = cond.af;
      flags_nxt[B_ZF] = cond.zf;
      flags_nxt[B_SF] = cond.sf;
      flags_nxt[B_OF] = cond.of;
    end
    flags_nxt = (flags_nxt & (MASK_CTRL | MASK_COND)) | FIXED_SET;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      res_wr  <= 1'b0;
      flags_q <= FIXED_SET;
    end else begin
      res_wr  <= do_wb;
      flags_q <= flags_nxt;
      if (do_wb) begin
        res_q <= result;
      end
    end
  end
endmodule

// File: rtl/alu_flagword_chk.sv
module alu_flagword_chk #(
  parameter int DATA_W = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       op_valid,
  input logic [3:0]                 op_code,
  input logic                       priv_wr,
  input logic [DATA_W-1:0]          res_q,
  input logic                       res_wr,
  input logic [alu_pkg::FLAG_W-1:0] flags_q
);
  import alu_pkg::*;

  // R11
  fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
    flags_q[B_ONE] && ((flags_q & ~(MASK_CTRL | MASK_COND | FIXED_SET)) == '0));

  // R8
  cmp_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CMP) |=> (!res_wr && $stable(res_q)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_code[3]) |=> (!res_wr && $stable(res_q) && $stable(flags_q & MASK_COND)));

  // R10
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !priv_wr |=> $stable(flags_q & MASK_CTRL));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    res_wr |-> (flags_q[B_ZF] == (res_q == '0)));

  // R6
  sign_flag_chk: assert property (@(posedge clk) disable iff (rst)
    res_wr |-> (flags_q[B_SF] == res_q[DATA_W-1]));

  // R4
  parity_flag_chk: assert property (@(posedge clk) disable iff (rst)
    res_wr |-> (flags_q[B_PF] == ~^res_q[7:0]));
endmodule

bind alu_flagword alu_flagword_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_code  (op_code),
  .priv_wr  (priv_wr),
  .res_q    (res_q),
  .res_wr   (res_wr),
  .flags_q  (flags_q)
);

// File: tb/alu_flagword_tb.sv
module alu_flagword_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic [3:0]   op_code = '0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic         priv_wr = 1'b0;
  logic [31:0]  priv_data = '0;
  logic [W-1:0] res_q;
  logic         res_wr;
  logic [31:0]  flags_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [W-1:0] exp_res   = '0;
  logic         exp_wr    = 1'b0;
  logic [31:0]  exp_flags = 32'h2;

  always #2 clk = ~clk;

  alu_flagword #(.DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .priv_wr(priv_wr), .priv_data(priv_data),
    .res_q(res_q), .res_wr(res_wr), .flags_q(flags_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 result", res_q, exp_res);
    chk("R8 writeback strobe", {31'b0, res_wr}, {31'b0, exp_wr});
    chk("R3 carry", {31'b0, flags_q[0]}, {31'b0, exp_flags[0]});
    chk("R4 parity", {31'b0, flags_q[2]}, {31'b0, exp_flags[2]});
    chk("R5 nibble carry", {31'b0, flags_q[4]}, {31'b0, exp_flags[4]});
    chk("R6 zero/sign", {30'b0, flags_q[7:6]}, {30'b0, exp_flags[7:6]});
    chk("R7 overflow", {31'b0, flags_q[11]}, {31'b0, exp_flags[11]});
    chk("R10 control bits", flags_q & 32'h3300, exp_flags & 32'h3300);
    chk("R11 fixed bits", flags_q & ~32'h3BD5, 32'h2);
  endtask

  // behavioural model of one edge
  task automatic model(input logic v, input logic [3:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic pw, input logic [31:0] pd);
    logic [31:0]  f;
    logic [W-1:0] r;
    logic         cf, af, of;
    longint ua, ub, sa, sb, cin, t, s;
    longint smax, smin;
    f = exp_flags;
    if (pw) f = (f & ~32'h3300) | (pd & 32'h3300);
    exp_wr = 1'b0;
    if (v && op < 8) begin
      ua = longint'({32'b0, a});
      ub = longint'({32'b0, b});
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      smax = (longint'(1) <<< (W-1)) - 1;
      smin = -(longint'(1) <<< (W-1));
      cin = (op == 1 || op == 3) ? longint'(exp_flags[0]) : 0;
      cf = 0; af = 0; of = 0; r = '0;
      if (op <= 1) begin
        t  = ua + ub + cin;
        r  = t[W-1:0];
        cf = (t >= (longint'(1) <<< W));
        af = ((ua % 16) + (ub % 16) + cin) > 15;
        s  = sa + sb + cin;
        of = (s > smax) || (s < smin);
      end else if (op == 2 || op == 3 || op == 7) begin
        t  = ua - ub - cin;
        r  = t[W-1:0];
        cf = ua < (ub + cin);
        af = (ua % 16) < ((ub % 16) + cin);
        s  = sa - sb - cin;
        of = (s > smax) || (s < smin);
      end else if (op == 4) r = a & b;
      else if (op == 5) r = a | b;
      else r = a ^ b;
      f[0] = cf; f[4] = af; f[11] = of;
      f[2] = ~^r[7:0];
      f[6] = (r == '0);
      f[7] = r[W-1];
      if (op != 7) begin
        exp_res = r;
        exp_wr  = 1'b1;
      end
    end
    exp_flags = f;
  endtask

  task automatic step(input logic v, input logic [3:0] op, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic pw, input logic [31:0] pd);
    op_valid = v; op_code = op; opnd_a = a; opnd_b = b; priv_wr = pw; priv_data = pd;
    @(posedge clk);
    model(v, op, a, b, pw, pd);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    chk("R1 reset result", res_q, '0);
    chk("R1 reset strobe", {31'b0, res_wr}, 32'h0);
    chk("R1 reset flags", flags_q, 32'h2);
    rst = 1'b0;

    // R7 signed overflow at positive limit
    step(1, 4'd0, 32'h7FFF_FFFF, 32'h1, 0, 0);
    // R3 R6 carry and zero together
    step(1, 4'd0, 32'hFFFF_FFFF, 32'h1, 0, 0);
    // R2 add with carry uses stored carry
    step(1, 4'd1, 32'h1000_0000, 32'h2, 0, 0);
    step(1, 4'd1, 32'h1000_0000, 32'h2, 0, 0);
    // R3 borrow on 0 - 1
    step(1, 4'd2, 32'h0, 32'h1, 0, 0);
    // R2 subtract with borrow chain
    step(1, 4'd3, 32'h5, 32'h3, 0, 0);
    step(1, 4'd3, 32'h8000_0000, 32'h1, 0, 0);
    // R8 compare equal: flags only
    step(1, 4'd7, 32'h1234_5678, 32'h1234_5678, 0, 0);
    chk("R8 compare keeps result", res_q, exp_res);
    step(1, 4'd7, 32'h0, 32'hFFFF_FFFF, 0, 0);
    // R7 logic clears carry and overflow
    step(1, 4'd2, 32'h0, 32'h1, 0, 0);
    step(1, 4'd4, 32'hF0F0_F0F0, 32'hFF00_FF0F, 0, 0);
    step(1, 4'd2, 32'h8000_0000, 32'h1, 0, 0);
    step(1, 4'd5, 32'h0, 32'h0, 0, 0);
    step(1, 4'd6, 32'hAAAA_5555, 32'h5555_AAAA, 0, 0);
    // R9 undefined code and idle ignored
    step(1, 4'd9, 32'h1, 32'h1, 0, 0);
    chk("R9 undefined opcode no strobe", {31'b0, res_wr}, 32'h0);
    step(0, 4'd0, 32'hFFFF_FFFF, 32'h1, 0, 0);
    chk("R9 idle keeps flags", flags_q, exp_flags);
    // R10 R11 privileged load with reserved bits set
    step(0, 4'd0, 0, 0, 1, 32'hFFFF_FFFF);
    chk("R11 reserved stay zero", flags_q & 32'hFFFF_C428, 32'h0);
    step(1, 4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 32'h0000_1100);
    step(1, 4'd2, 32'h3, 32'h5, 0, 0);

    for (int i = 0; i < 400; i++) begin
      logic [3:0] rop;
      rop = (i % 16 == 15) ? 4'($urandom_range(8, 15)) : 4'($urandom_range(0, 7));
      step(($urandom % 8) != 0, rop,
           (i % 5 == 0) ? 32'hFFFF_FFFF : $urandom,
           (i % 7 == 0) ? 32'h8000_0000 : $urandom,
           ($urandom % 10) == 0, $urandom);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule